// File: doc/BRIEF.md
# Write-Combining Line Buffer Array

This block gathers stores aimed at write-combining memory into a small pool of line buffers. Each buffer is 64 bytes long. A buffer is claimed by the first store to a line, and later stores to the same line merge their bytes into it. Buffers leave through a valid/ready flush port as a line base address, a 64-bit byte-valid mask and 512 bits of line data. The bus transaction that follows the flush is outside this block.

A buffer goes to the flush port in three cases:
- All 64 of its bytes have been written.
- A drain event arrives, such as a fence, a serializing operation, an I/O access, a locked read-modify-write, an interrupt acknowledge or a bus initialization. The core combines these into the single pulse `drain_req`.
- A store names a new line and no usable buffer is free. The oldest buffer is then evicted and the store waits.

There are six buffers. The two highest-numbered buffers can be taken away for another use through `rsv_in`. Stores are one 8-byte word wide. The store address is given as a word address: the low three bits name the word within the line and the upper bits name the line. Buffers may leave in an order that differs from program order.

Top module: `wcb_array`

## Requirements
- R1: A store to a line that a buffer already holds merges into that buffer. No two buffers ever hold the same line, and a line written through one buffer leaves in exactly one flush.
- R2: When a byte is written more than once before its flush, the flush carries the value of the last write, and the flush mask has a bit set for every byte written.
- R3: A buffer whose 64 mask bits are all set is flushed without any drain request.
- R4: One cycle of `drain_req` flushes every occupied buffer. While the drain is in progress, `st_stall` is high for any valid store. When all buffers are empty, `drain_done` pulses high for exactly one cycle.
- R5: A store to a line held in no buffer, when no usable buffer is free, sees `st_stall` high. The buffer allocated longest ago is flushed, and the store is accepted after that flush.
- R6: While `rsv_in` is high, buffers 4 and 5 are never allocated, and any line they hold is flushed. Buffers 0 to 3 are always usable.
- R7: A store that hits a buffer already chosen for flushing stalls until that buffer has left. It then starts a new buffer that holds only its own bytes.
- R8: While `fl_valid` is high and `fl_ready` is low, `fl_valid`, `fl_base` and `fl_mask` hold. A buffer is freed on the cycle of the handshake.
- R9: After reset, `st_stall`, `fl_valid` and `drain_done` are low and every buffer is empty.
- R10: Byte placement follows these rules:
  - `st_qaddr[2:0]` selects the word within the line.
  - Store enable bit k writes line byte 8*word+k.
  - Line byte j travels in `fl_data[8j+7:8j]` and in `fl_mask[j]`.
  - `fl_base` equals `st_qaddr[QA_W-1:3]` of the stores that filled the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store offered this cycle |
| st_qaddr | input | 29 | Word address: line number above, word-in-line in bits 2:0 |
| st_be | input | 8 | Byte enables within the word |
| st_data | input | 64 | Store data, byte k in bits 8k+7:8k |
| st_stall | output | 1 | Store not taken this cycle; hold it |
| drain_req | input | 1 | One-cycle pulse: flush every buffer |
| rsv_in | input | 1 | Take buffers 4 and 5 out of write-combining use |
| fl_valid | output | 1 | A buffer is presented for flushing |
| fl_ready | input | 1 | Flush taker accepts the buffer |
| fl_base | output | 26 | Line number of the flushed buffer |
| fl_mask | output | 64 | Byte-valid mask of the flushed line |
| fl_data | output | 512 | Line data |
| drain_done | output | 1 | One-cycle pulse when a drain has emptied all buffers |

## Verification
A wrong merge or lookup state shows up at the flush port on the next flush of the line concerned. A scoreboard keeps a shadow image of every open line, so a lost byte, a stale byte or a line split into two flushes appears as a mask or data mismatch, or as a flush of an unexpected line. A wrong age order or reservation state shows up as the wrong line being evicted, which is visible a few cycles after the stalled store appears. A stuck drain or occupancy state shows up as `drain_done` never arriving, or as `st_stall` staying high, within the bench's per-scenario waits.

// File: rtl/wcb_pkg.sv
package wcb_pkg;
  localparam int ADDR_W     = 32;
  localparam int LINE_BYTES = 64;
  localparam int WORD_BYTES = 8;

  localparam int LINE_BITS = LINE_BYTES * 8;
  localparam int WORD_BITS = WORD_BYTES * 8;
  localparam int OFF_W     = $clog2(LINE_BYTES);
  localparam int WOFF_W    = $clog2(WORD_BYTES);
  localparam int WIDX_W    = OFF_W - WOFF_W;
  localparam int BASE_W    = ADDR_W - OFF_W;
  localparam int QA_W      = ADDR_W - WOFF_W;

  typedef logic [BASE_W-1:0]     base_t;
  typedef logic [LINE_BYTES-1:0] lmask_t;
  typedef logic [LINE_BITS-1:0]  ldata_t;
  typedef logic [WORD_BYTES-1:0] wbe_t;
  typedef logic [WORD_BITS-1:0]  wdata_t;
  typedef logic [WIDX_W-1:0]     widx_t;
  typedef logic [QA_W-1:0]       qaddr_t;

  function automatic base_t line_of(input qaddr_t qa);
    return qa[QA_W-1:WIDX_W];
  endfunction

  function automatic widx_t word_of(input qaddr_t qa);
    return qa[WIDX_W-1:0];
  endfunction

  function automatic lmask_t spread_be(input wbe_t be, input widx_t idx);
    lmask_t m;
    m = lmask_t'(be);
    return m << (int'(idx) * WORD_BYTES);
  endfunction

  function automatic ldata_t spread_data(input wdata_t d, input widx_t idx);
    ldata_t v;
    v = ldata_t'(d);
    return v << (int'(idx) * WORD_BITS);
  endfunction

  function automatic ldata_t merge_bytes(input ldata_t old_v, input ldata_t new_v,
                                         input lmask_t m);
    ldata_t r;
    for (int b = 0; b < LINE_BYTES; b++)
      r[b*8 +: 8] = m[b] ? new_v[b*8 +: 8] : old_v[b*8 +: 8];
    return r;
  endfunction

  function automatic logic all_set(input lmask_t m);
    return &m;
  endfunction
endpackage

// File: rtl/wcb_line.sv
module wcb_line
  import wcb_pkg::*;
#(
  parameter int RANK_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_i,
  input  logic              merge_i,
  input  logic              mark_i,
  input  logic              release_i,
  input  logic              rank_dec_i,
  input  base_t             base_i,
  input  lmask_t            wmask_i,
  input  ldata_t            wdata_i,
  input  logic [RANK_W-1:0] rank_i,
  output logic              occ_o,
  output logic              pend_o,
  output base_t             base_o,
  output lmask_t            mask_o,
  output ldata_t            data_o,
  output logic [RANK_W-1:0] rank_o
);
  lmask_t mask_next;
  assign mask_next = mask_o | wmask_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ_o  <= 1'b0;
      pend_o <= 1'b0;
      base_o <= '0;
      mask_o <= '0;
      data_o <= '0;
      rank_o <= '0;
    end else if (release_i) begin
      occ_o  <= 1'b0;
      pend_o <= 1'b0;
      mask_o <= '0;
    end else begin
      if (alloc_i) begin
        occ_o  <= 1'b1;
        base_o <= base_i;
        mask_o <= wmask_i;
        data_o <= merge_bytes('0, wdata_i, wmask_i);
        pend_o <= all_set(wmask_i);
        rank_o <= rank_i;
      end else if (merge_i) begin
        mask_o <= mask_next;
        data_o <= merge_bytes(data_o, wdata_i, wmask_i);
        if (all_set(mask_next)) pend_o <= 1'b1;
      end
      if (mark_i && occ_o) pend_o <= 1'b1;
      if (rank_dec_i) rank_o <= rank_o - 1'b1;
    end
  end
endmodule

// File: rtl/wcb_lookup.sv
module wcb_lookup
  import wcb_pkg::*;
#(
  parameter int NUM_BUF = 6,
  parameter int NUM_RSV = 2,
  parameter int IDX_W   = 3
) (
  input  logic [NUM_BUF-1:0]             occ_vec,
  input  logic [NUM_BUF-1:0]             pend_vec,
  input  logic [NUM_BUF-1:0][BASE_W-1:0] base_arr,
  input  logic [NUM_BUF-1:0][IDX_W-1:0]  rank_arr,
  input  logic                           rsv_in,
  input  base_t                          st_base,
  output logic [NUM_BUF-1:0]             hit_vec,
  output logic                           hit_any,
  output logic                           hit_pend,
  output logic                           free_any,
  output logic [IDX_W-1:0]               free_idx,
  output logic [IDX_W-1:0]               oldest_idx
);
  localparam int KEEP = NUM_BUF - NUM_RSV;

  logic [NUM_BUF-1:0] usable;
  logic [NUM_BUF-1:0] free_vec;

  for (genvar i = 0; i < NUM_BUF; i++) begin : g_cmp
    if (i < KEEP) begin : g_keep
      assign usable[i] = 1'b1;
    end else begin : g_rsv
      assign usable[i] = ~rsv_in;
    end
    assign hit_vec[i]  = occ_vec[i] && (base_arr[i] == st_base);
    assign free_vec[i] = ~occ_vec[i] && usable[i];
  end

  assign hit_any  = |hit_vec;
  assign hit_pend = |(hit_vec & pend_vec);
  assign free_any = |free_vec;

  always_comb begin
    free_idx   = '0;
    oldest_idx = '0;
    for (int i = NUM_BUF - 1; i >= 0; i--) begin
      if (free_vec[i]) free_idx = IDX_W'(i);
      if (occ_vec[i] && rank_arr[i] == '0) oldest_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/wcb_flush_sel.sv
module wcb_flush_sel #(
  parameter int NUM_BUF = 6,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_BUF-1:0] pend_vec,
  input  logic               fl_ready,
  output logic               busy_o,
  output logic [IDX_W-1:0]   sel_o,
  output logic               done_o
);
  logic [IDX_W-1:0] pick;

  always_comb begin
    pick = '0;
    for (int i = NUM_BUF - 1; i >= 0; i--)
      if (pend_vec[i]) pick = IDX_W'(i);
  end

  assign done_o = busy_o && fl_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      sel_o  <= '0;
    end else if (done_o) begin
      busy_o <= 1'b0;
    end else if (!busy_o && |pend_vec) begin
      busy_o <= 1'b1;
      sel_o  <= pick;
    end
  end
endmodule

// File: rtl/wcb_array.sv
module wcb_array
  import wcb_pkg::*;
#(
  parameter int NUM_BUF = 6,
  parameter int NUM_RSV = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  st_valid,
  input  logic [QA_W-1:0]       st_qaddr,
  input  logic [WORD_BYTES-1:0] st_be,
  input  logic [WORD_BITS-1:0]  st_data,
  output logic                  st_stall,
  input  logic                  drain_req,
  input  logic                  rsv_in,
  output logic                  fl_valid,
  input  logic                  fl_ready,
  output logic [BASE_W-1:0]     fl_base,
  output logic [LINE_BYTES-1:0] fl_mask,
  output logic [LINE_BITS-1:0]  fl_data,
  output logic                  drain_done
);
  localparam int IDX_W = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1;
  localparam int CNT_W = $clog2(NUM_BUF + 1);
  localparam int KEEP  = NUM_BUF - NUM_RSV;

  base_t  st_base;
  lmask_t st_wmask;
  ldata_t st_wdata;

  assign st_base  = line_of(st_qaddr);
  assign st_wmask = spread_be(st_be, word_of(st_qaddr));
  assign st_wdata = spread_data(st_data, word_of(st_qaddr));

  logic [NUM_BUF-1:0]             occ_vec, pend_vec, hit_vec;
  logic [NUM_BUF-1:0]             alloc_vec, merge_vec, mark_vec, release_vec, dec_vec;
  logic [NUM_BUF-1:0][BASE_W-1:0] base_arr;
  logic [NUM_BUF-1:0][IDX_W-1:0]  rank_arr;
  lmask_t                         mask_arr [NUM_BUF];
  ldata_t                         data_arr [NUM_BUF];

  logic             hit_any, hit_pend, free_any;
  logic [IDX_W-1:0] free_idx, oldest_idx, fl_sel;
  logic             fl_done;
  logic             drain_act;
  logic             st_accept, evict_need, all_empty;
  logic [CNT_W-1:0] occ_cnt;
  logic [IDX_W-1:0] rank_new;

  wcb_lookup #(
    .NUM_BUF(NUM_BUF), .NUM_RSV(NUM_RSV), .IDX_W(IDX_W)
  ) u_lookup (
    .occ_vec(occ_vec), .pend_vec(pend_vec), .base_arr(base_arr), .rank_arr(rank_arr),
    .rsv_in(rsv_in), .st_base(st_base), .hit_vec(hit_vec), .hit_any(hit_any),
    .hit_pend(hit_pend), .free_any(free_any), .free_idx(free_idx),
    .oldest_idx(oldest_idx)
  );

  wcb_flush_sel #(
    .NUM_BUF(NUM_BUF), .IDX_W(IDX_W)
  ) u_flush (
    .clk(clk), .rst_n(rst_n), .pend_vec(pend_vec), .fl_ready(fl_ready),
    .busy_o(fl_valid), .sel_o(fl_sel), .done_o(fl_done)
  );

  assign st_stall   = st_valid && (drain_act || hit_pend || (!hit_any && !free_any));
  assign st_accept  = st_valid && !st_stall && (st_be != '0);
  assign evict_need = st_valid && !drain_act && !hit_any && !free_any;
  assign all_empty  = (occ_vec == '0);
  assign occ_cnt    = CNT_W'($countones(occ_vec));
  assign rank_new   = IDX_W'(occ_cnt - (fl_done ? CNT_W'(1) : CNT_W'(0)));

  for (genvar i = 0; i < NUM_BUF; i++) begin : g_buf
    logic rsv_here;
    if (i < KEEP) begin : g_keep
      assign rsv_here = 1'b0;
    end else begin : g_rsv
      assign rsv_here = rsv_in;
    end

    assign alloc_vec[i]   = st_accept && !hit_any && (free_idx == IDX_W'(i));
    assign merge_vec[i]   = st_accept && hit_vec[i];
    assign mark_vec[i]    = occ_vec[i] && (drain_act || rsv_here ||
                            (evict_need && oldest_idx == IDX_W'(i)));
    assign release_vec[i] = fl_done && (fl_sel == IDX_W'(i));
    assign dec_vec[i]     = fl_done && occ_vec[i] && !release_vec[i] &&
                            (rank_arr[i] > rank_arr[fl_sel]);

    wcb_line #(.RANK_W(IDX_W)) u_line (
      .clk(clk), .rst_n(rst_n),
      .alloc_i(alloc_vec[i]), .merge_i(merge_vec[i]), .mark_i(mark_vec[i]),
      .release_i(release_vec[i]), .rank_dec_i(dec_vec[i]),
      .base_i(st_base), .wmask_i(st_wmask), .wdata_i(st_wdata), .rank_i(rank_new),
      .occ_o(occ_vec[i]), .pend_o(pend_vec[i]), .base_o(base_arr[i]),
      .mask_o(mask_arr[i]), .data_o(data_arr[i]), .rank_o(rank_arr[i])
    );
  end

  assign fl_base = base_arr[fl_sel];
  assign fl_mask = mask_arr[fl_sel];
  assign fl_data = data_arr[fl_sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drain_act  <= 1'b0;
      drain_done <= 1'b0;
    end else begin
      drain_done <= drain_act && all_empty;
      if (drain_req)                   drain_act <= 1'b1;
      else if (drain_act && all_empty) drain_act <= 1'b0;
    end
  end
endmodule

// File: rtl/wcb_array_chk.sv
module wcb_array_chk
  import wcb_pkg::*;
#(
  parameter int NUM_BUF = 6,
  parameter int NUM_RSV = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               st_valid,
  input logic               st_stall,
  input logic               fl_valid,
  input logic               fl_ready,
  input base_t              fl_base,
  input lmask_t             fl_mask,
  input logic               drain_done,
  input logic               rsv_in,
  input logic [NUM_BUF-1:0] occ_vec,
  input logic [NUM_BUF-1:0] pend_vec,
  input logic [NUM_BUF-1:0] hit_vec,
  input logic [NUM_BUF-1:0] alloc_vec,
  input logic               drain_act,
  input logic               evict_need
);
  localparam logic [NUM_BUF-1:0] RSV_SET =
    NUM_BUF'(((1 << NUM_RSV) - 1) << (NUM_BUF - NUM_RSV));

  // R1
  one_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R8
  flush_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_valid && !fl_ready |=> fl_valid && $stable(fl_base) && $stable(fl_mask));

  // R8
  flush_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_valid |-> fl_mask != '0);

  // R4
  drain_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drain_done |-> occ_vec == '0);

  // R4
  drain_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && drain_act |-> st_stall);

  // R6
  rsv_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsv_in |-> (alloc_vec & RSV_SET) == '0);

  // R5
  evict_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evict_need |-> st_stall);

  // R7
  pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(pend_vec) & ~pend_vec)) |-> $past(fl_valid && fl_ready));
endmodule

bind wcb_array wcb_array_chk #(.NUM_BUF(NUM_BUF), .NUM_RSV(NUM_RSV)) u_chk (
  .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_stall(st_stall),
  .fl_valid(fl_valid), .fl_ready(fl_ready), .fl_base(fl_base), .fl_mask(fl_mask),
  .drain_done(drain_done), .rsv_in(rsv_in), .occ_vec(occ_vec), .pend_vec(pend_vec),
  .hit_vec(hit_vec), .alloc_vec(alloc_vec), .drain_act(drain_act),
  .evict_need(evict_need)
);

// File: tb/wcb_array_test.sv
module wcb_array_test;
  import wcb_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic   rst_n, st_valid, st_stall, drain_req, rsv_in;
  logic   fl_valid, fl_ready, drain_done;
  qaddr_t st_qaddr;
  wbe_t   st_be;
  wdata_t st_data;
  base_t  fl_base;
  lmask_t fl_mask;
  ldata_t fl_data;

  wcb_array uut (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_qaddr(st_qaddr),
    .st_be(st_be), .st_data(st_data), .st_stall(st_stall), .drain_req(drain_req),
    .rsv_in(rsv_in), .fl_valid(fl_valid), .fl_ready(fl_ready), .fl_base(fl_base),
    .fl_mask(fl_mask), .fl_data(fl_data), .drain_done(drain_done)
  );

  int vectors = 0, miscompares = 0, cycles = 0, done_pulses = 0;
  lmask_t sb_mask [base_t];
  ldata_t sb_data [base_t];
  base_t  flushed_q [$];
  lmask_t last_mask;
  ldata_t last_data;
  bit     last_stalled;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic ldata_t byte_bits(input lmask_t m);
    ldata_t r;
    for (int b = 0; b < LINE_BYTES; b++) r[b*8 +: 8] = {8{m[b]}};
    return r;
  endfunction

  // monitor: pops the shadow line of each flushed buffer and compares
  always @(negedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
    if (rst_n && fl_valid && fl_ready) begin
      if (sb_mask.exists(fl_base)) begin
        check(fl_mask == sb_mask[fl_base], "R2", "flush mask", fl_mask, sb_mask[fl_base]);
        check(((fl_data ^ sb_data[fl_base]) & byte_bits(fl_mask)) == '0, "R10",
              "flush data bytes", 1, 0);
        sb_mask.delete(fl_base);
        sb_data.delete(fl_base);
      end else begin
        check(1'b0, "R1", "flush of a line with no open shadow", fl_base, 0);
      end
      last_mask = fl_mask;
      last_data = fl_data;
      flushed_q.push_back(fl_base);
    end
    if (rst_n && drain_done) done_pulses++;
  end

  // driver: offers one store, waits through stalls, updates the shadow on acceptance
  task automatic do_store(input base_t b, input int w, input wbe_t be, input wdata_t d);
    @(negedge clk);
    st_valid = 1'b1;
    st_qaddr = {b, widx_t'(w)};
    st_be    = be;
    st_data  = d;
    last_stalled = 1'b0;
    #1;
    while (st_stall) begin
      last_stalled = 1'b1;
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    if (!sb_mask.exists(b)) begin
      sb_mask[b] = '0;
      sb_data[b] = '0;
    end
    for (int k = 0; k < WORD_BYTES; k++) begin
      if (be[k]) begin
        sb_mask[b][w*WORD_BYTES + k] = 1'b1;
        sb_data[b][(w*WORD_BYTES + k)*8 +: 8] = d[k*8 +: 8];
      end
    end
    #1;
    st_valid = 1'b0;
  endtask

  task automatic do_drain(input string req);
    int start;
    start = done_pulses;
    @(negedge clk);
    drain_req = 1'b1;
    @(negedge clk);
    drain_req = 1'b0;
    while (done_pulses == start) @(negedge clk);
    check(sb_mask.num() == 0, req, "open lines after drain", sb_mask.num(), 0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int n0;
    base_t b0;
    rst_n = 1'b0; st_valid = 1'b0; st_qaddr = '0; st_be = '0; st_data = '0;
    drain_req = 1'b0; rsv_in = 1'b0; fl_ready = 1'b1;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    check(st_stall == 1'b0, "R9", "stall after reset", st_stall, 0);
    check(fl_valid == 1'b0, "R9", "flush valid after reset", fl_valid, 0);
    check(drain_done == 1'b0, "R9", "drain done after reset", drain_done, 0);

    // R3: eight full words fill a line, which leaves on its own
    for (int w = 0; w < 8; w++) do_store(26'h040, w, 8'hFF, {8{8'(8'h10 + w)}});
    idle(6);
    check(flushed_q.size() == 1 && flushed_q[0] == 26'h040, "R3",
          "auto flush of full line", flushed_q.size(), 1);
    check(last_mask == '1, "R3", "full line mask", last_mask, 64'hFFFF_FFFF_FFFF_FFFF);

    // R2 and R1: overlapping writes merge into one buffer, last value wins
    n0 = flushed_q.size();
    do_store(26'h051, 2, 8'h0F, 64'hAAAA_AAAA_AAAA_AAAA);
    do_store(26'h051, 2, 8'h03, 64'h5555_5555_5555_5555);
    do_store(26'h051, 6, 8'h80, 64'h7700_0000_0000_0000);
    do_drain("R4");
    check(flushed_q.size() == n0 + 1, "R1", "single flush for merged line",
          flushed_q.size() - n0, 1);
    check(last_data[8*16 +: 16] == 16'h5555 && last_data[8*18 +: 16] == 16'hAAAA,
          "R2", "overwritten bytes", last_data[8*16 +: 32], 32'hAAAA_5555);

    // R10: byte placement within the line
    do_store(26'h062, 5, 8'h81, 64'h1122_3344_5566_7788);
    do_drain("R4");
    check(last_mask == (64'h81 << 40), "R10", "placed mask", last_mask, 64'h81 << 40);
    check(last_data[8*40 +: 8] == 8'h88 && last_data[8*47 +: 8] == 8'h11, "R10",
          "placed bytes", {last_data[8*47 +: 8], last_data[8*40 +: 8]}, 16'h1188);

    // R5: seven lines in six buffers evicts the first one allocated
    for (int i = 0; i < 6; i++) do_store(26'h100 + base_t'(i), 0, 8'h01, 64'(i + 1));
    n0 = flushed_q.size();
    do_store(26'h106, 0, 8'h01, 64'h77);
    check(last_stalled == 1'b1, "R5", "stall on new line with no free buffer",
          last_stalled, 1);
    check(flushed_q.size() == n0 + 1 && flushed_q[n0] == 26'h100, "R5",
          "oldest line evicted", flushed_q[flushed_q.size()-1], 26'h100);
    do_drain("R4");

    // R6: reservation flushes buffers 4 and 5 and keeps them out of use
    for (int i = 0; i < 6; i++) do_store(26'h200 + base_t'(i), 1, 8'h02, 64'(i << 8));
    n0 = flushed_q.size();
    @(negedge clk);
    rsv_in = 1'b1;
    idle(10);
    check(flushed_q.size() == n0 + 2 && flushed_q[n0] == 26'h204 &&
          flushed_q[n0+1] == 26'h205, "R6", "reserved buffers flushed",
          flushed_q.size() - n0, 2);
    do_store(26'h206, 3, 8'h10, 64'h0000_0099_0000_0000);
    check(last_stalled == 1'b1, "R6", "no allocation into reserved buffers",
          last_stalled, 1);
    check(flushed_q[flushed_q.size()-1] == 26'h200, "R6", "oldest usable evicted",
          flushed_q[flushed_q.size()-1], 26'h200);
    do_drain("R4");
    rsv_in = 1'b0;

    // R7: store to a line already chosen for flushing waits and starts fresh
    for (int w = 0; w < 8; w++) do_store(26'h300, w, 8'hFF, {8{8'(8'hC0 + w)}});
    do_store(26'h300, 1, 8'h01, 64'h3C);
    check(last_stalled == 1'b1, "R7", "stall on hit to pending buffer", last_stalled, 1);
    check(flushed_q[flushed_q.size()-1] == 26'h300, "R7", "full line left first",
          flushed_q[flushed_q.size()-1], 26'h300);
    do_drain("R4");
    check(last_mask == 64'h100, "R7", "fresh buffer holds only new byte", last_mask, 64'h100);

    // R8 and R4: flush output holds under back-pressure; stores stall in a drain
    do_store(26'h400, 0, 8'h01, 64'h01);
    do_store(26'h401, 0, 8'h01, 64'h02);
    n0 = done_pulses;
    @(negedge clk);
    fl_ready = 1'b0;
    drain_req = 1'b1;
    @(negedge clk);
    drain_req = 1'b0;
    idle(3);
    check(fl_valid == 1'b1, "R8", "flush offered during drain", fl_valid, 1);
    b0 = fl_base;
    idle(2);
    check(fl_valid == 1'b1 && fl_base == b0, "R8", "flush held without ready", fl_base, b0);
    st_valid = 1'b1;
    st_qaddr = {26'h400, 3'd1};
    st_be = 8'h01;
    st_data = 64'h5;
    #1;
    check(st_stall == 1'b1, "R4", "store stalled during drain", st_stall, 1);
    st_valid = 1'b0;
    @(negedge clk);
    fl_ready = 1'b1;
    while (done_pulses == n0) @(negedge clk);
    check(sb_mask.num() == 0, "R4", "all lines flushed by drain", sb_mask.num(), 0);
    idle(1);
    check(drain_done == 1'b0, "R4", "drain done lasts one cycle", drain_done, 0);

    // R4: drain of an empty array still completes
    do_drain("R4");
    check(done_pulses == n0 + 2, "R4", "drain done pulses", done_pulses - n0, 2);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule